// File: doc/BRIEF.md
# Hart Debug Halt, Step and Trigger Controller

This block sits beside a hart's commit stage and decides when the hart leaves normal execution and parks in debug mode. It watches the instruction that is about to commit, takes level halt and resume requests from an external debug module, and holds the debug control/status word, the saved debug PC and one execute-address trigger. Three events send the hart into debug mode: a halt request, the end of a single-stepped instruction and a trigger match. Each event records its own cause code.

While parked, the hart's pipeline is held and any instruction it offers is killed. The debug module reads and writes the controller's registers through a simple combinational register port. Register writes are taken only while the hart is halted. A resume request sends the hart back to the saved PC and produces a one-cycle acknowledge. A halt request that arrives while the hart sleeps in a wait-for-interrupt also raises a wake line to the core.

Top module: `hart_debug_ctrl`

## Requirements
- R1: After reset the hart runs (`halted_o`=0). The status word at 0x7B0 reads 0x40000003: version 4 in bits 31:28, cause 0 in bits 8:6, step bit 2 clear and privilege 3 in bits 1:0. The trigger control word at 0x7A1 reads 0xF0000000.
- R2: A halt request while running kills the instruction offered in that cycle and halts the hart on the next edge. Cause 3 goes to status bits 8:6. The saved PC at 0x7B1 becomes the killed instruction's address, or the next sequential PC if no instruction was offered.
- R3: Once halted, the hart stays halted for any number of cycles until a resume request arrives. Every instruction offered meanwhile is killed.
- R4: A resume request with no halt request, while halted, makes the hart run from the next edge. `resume_ack_o` is high for exactly that one cycle, and `resume_pc_o` equals the saved PC.
- R5: With status bit 2 (step) set, each resume lets exactly one instruction commit. The hart then halts with cause 4 and a saved PC 4 above that instruction.
- R6: An armed trigger whose match address at 0x7A2 equals the offered PC kills that instruction. The hart halts with cause 2, and the saved PC equals the matched address.
- R7: A write to 0x7A1 whose bits 31:28 are not 6 makes it read 0xF0000000 and disarms the trigger. A type-6 value reads back exactly. It arms only if bits 15:12 equal 1, bit 6 is set and bit 2 is set (e.g. 0x62431044).
- R8: 0x7A4 reads 0x01000040 and 0x7A0 always reads 0. `csr_hit_o` is 1 for 0x7A0, 0x7A1, 0x7A2, 0x7A4, 0x7B0 and 0x7B1 and 0 for any other address.
- R9: The first instruction after a resume never fires the trigger, so resuming at a breakpointed address makes progress. Later instructions at that address do fire it.
- R10: `wfi_wake_o` is high when the hart is running, `wfi_i` is high and a halt request is present. The hart then halts with cause 3.
- R11: Register writes while the hart is running have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req_i | input | 1 | Level halt request from the debug module |
| resume_req_i | input | 1 | Resume request from the debug module |
| wfi_i | input | 1 | Hart is stalled in wait-for-interrupt |
| insn_valid_i | input | 1 | An instruction is offered for commit |
| insn_pc_i | input | XLEN | Address of the offered instruction |
| csr_we_i | input | 1 | Register write strobe |
| csr_addr_i | input | 12 | Register address |
| csr_wdata_i | input | XLEN | Register write data |
| csr_rdata_o | output | XLEN | Register read data (combinational) |
| csr_hit_o | output | 1 | Address names an existing register |
| insn_kill_o | output | 1 | Offered instruction must not commit |
| halted_o | output | 1 | Hart is in debug mode |
| resume_ack_o | output | 1 | One-cycle pulse when the hart runs again |
| resume_pc_o | output | XLEN | PC at which execution restarts |
| wfi_wake_o | output | 1 | Wake the hart out of wait-for-interrupt |

## Verification
The hardest state to reach is a trigger match on the very instruction the hart resumes at, with the hart then looping back to that address. The stimulus first arms the trigger and walks the PC sequentially from the saved PC up to the match, one instruction per cycle. It then resumes at the matched address, commits it and one successor, and offers the matched address again to see the match return. Single-step is swept over several consecutive resumes, with the expected saved PC advanced by 4 each time.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

  typedef enum logic [2:0] {
    CAUSE_NONE    = 3'd0,
    CAUSE_TRIGGER = 3'd2,
    CAUSE_HALTREQ = 3'd3,
    CAUSE_STEP    = 3'd4
  } cause_e;

  localparam logic [11:0] A_TSEL  = 12'h7A0;
  localparam logic [11:0] A_TCTL  = 12'h7A1;
  localparam logic [11:0] A_TADDR = 12'h7A2;
  localparam logic [11:0] A_TINFO = 12'h7A4;
  localparam logic [11:0] A_DSTAT = 12'h7B0;
  localparam logic [11:0] A_DPC   = 12'h7B1;

  localparam logic [3:0]  TRIG_TYPE_EXEC = 4'd6;
  localparam logic [3:0]  TRIG_TYPE_OFF  = 4'hF;
  localparam logic [3:0]  TRIG_ACT_DEBUG = 4'd1;
  localparam logic [31:0] TINFO_VALUE    = 32'h0100_0040;
  localparam logic [3:0]  DEBUG_VERSION  = 4'd4;

endpackage

// File: rtl/dbg_trigger.sv
module dbg_trigger #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_ctl,
  input  logic            wr_addr,
  input  logic [XLEN-1:0] wdata,
  input  logic            cmp_valid,
  input  logic [XLEN-1:0] cmp_pc,
  input  logic            suppress,
  output logic [XLEN-1:0] ctl_q,
  output logic [XLEN-1:0] addr_q,
  output logic            hit
);
  import dbg_pkg::*;

  localparam logic [XLEN-1:0] CTL_OFF = {TRIG_TYPE_OFF, {(XLEN-4){1'b0}}};

  logic [XLEN-1:0] ctl_d, addr_d;
  logic            ctl_en, addr_en;
  logic            armed;

  always_comb begin
    ctl_en  = wr_ctl;
    addr_en = wr_addr;
    ctl_d   = (wdata[XLEN-1 -: 4] == TRIG_TYPE_EXEC) ? wdata : CTL_OFF;
    addr_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= CTL_OFF;
      addr_q <= '0;
    end else begin
      if (ctl_en)  ctl_q  <= ctl_d;
      if (addr_en) addr_q <= addr_d;
    end
  end

  always_comb begin
    armed = (ctl_q[XLEN-1 -: 4] == TRIG_TYPE_EXEC) &&
            (ctl_q[15:12] == TRIG_ACT_DEBUG) && ctl_q[6] && ctl_q[2];
    hit   = armed && cmp_valid && !suppress && (cmp_pc == addr_q);
  end

endmodule

// File: rtl/dbg_csr_port.sv
module dbg_csr_port #(
  parameter int XLEN = 32
) (
  input  logic            halted,
  input  logic            we,
  input  logic [11:0]     addr,
  input  logic [XLEN-1:0] dstat,
  input  logic [XLEN-1:0] dpc,
  input  logic [XLEN-1:0] tctl,
  input  logic [XLEN-1:0] taddr,
  output logic [XLEN-1:0] rdata,
  output logic            hit,
  output logic            wr_dstat,
  output logic            wr_dpc,
  output logic            wr_tctl,
  output logic            wr_taddr
);
  import dbg_pkg::*;

  logic wr_ok;

  always_comb begin
    wr_ok = we && halted;
    hit   = 1'b1;
    rdata = '0;
    unique case (addr)
      A_TSEL:  rdata = '0;
      A_TCTL:  rdata = tctl;
      A_TADDR: rdata = taddr;
      A_TINFO: rdata = XLEN'(TINFO_VALUE);
      A_DSTAT: rdata = dstat;
      A_DPC:   rdata = dpc;
      default: hit = 1'b0;
    endcase
    wr_dstat = wr_ok && (addr == A_DSTAT);
    wr_dpc   = wr_ok && (addr == A_DPC);
    wr_tctl  = wr_ok && (addr == A_TCTL);
    wr_taddr = wr_ok && (addr == A_TADDR);
  end

endmodule

// File: rtl/dbg_halt_fsm.sv
module dbg_halt_fsm #(
  parameter int XLEN    = 32,
  parameter int PC_STEP = 4,
  parameter logic [XLEN-1:0] BOOT_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            halt_req,
  input  logic            resume_req,
  input  logic            insn_valid,
  input  logic [XLEN-1:0] insn_pc,
  input  logic            trig_hit,
  input  logic            wr_dstat,
  input  logic            wr_dpc,
  input  logic [XLEN-1:0] wdata,
  output logic            halted_q,
  output logic [2:0]      cause_q,
  output logic            step_q,
  output logic [XLEN-1:0] dpc_q,
  output logic            first_q,
  output logic            ack_q,
  output logic            kill
);
  import dbg_pkg::*;

  localparam logic [XLEN-1:0] INC = XLEN'(PC_STEP);

  logic            halted_d, step_d, first_d, ack_d;
  logic [2:0]      cause_d;
  logic [XLEN-1:0] dpc_d, npc_d, npc_q;

  always_comb begin
    halted_d = halted_q;
    cause_d  = cause_q;
    step_d   = step_q;
    dpc_d    = dpc_q;
    npc_d    = npc_q;
    first_d  = first_q;
    ack_d    = 1'b0;
    kill     = 1'b0;
    if (!halted_q) begin
      if (insn_valid) begin
        if (trig_hit) begin
          kill     = 1'b1;
          halted_d = 1'b1;
          cause_d  = CAUSE_TRIGGER;
          dpc_d    = insn_pc;
        end else if (halt_req) begin
          kill     = 1'b1;
          halted_d = 1'b1;
          cause_d  = CAUSE_HALTREQ;
          dpc_d    = insn_pc;
        end else begin
          npc_d   = insn_pc + INC;
          first_d = 1'b0;
          if (step_q) begin
            halted_d = 1'b1;
            cause_d  = CAUSE_STEP;
            dpc_d    = insn_pc + INC;
          end
        end
      end else if (halt_req) begin
        halted_d = 1'b1;
        cause_d  = CAUSE_HALTREQ;
        dpc_d    = npc_q;
      end
    end else begin
      kill = insn_valid;
      if (wr_dstat) step_d = wdata[2];
      if (wr_dpc)   dpc_d  = wdata;
      if (resume_req && !halt_req) begin
        halted_d = 1'b0;
        ack_d    = 1'b1;
        first_d  = 1'b1;
        npc_d    = wr_dpc ? wdata : dpc_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted_q <= 1'b0;
      cause_q  <= CAUSE_NONE;
      step_q   <= 1'b0;
      dpc_q    <= '0;
      npc_q    <= BOOT_PC;
      first_q  <= 1'b0;
      ack_q    <= 1'b0;
    end else begin
      halted_q <= halted_d;
      cause_q  <= cause_d;
      step_q   <= step_d;
      dpc_q    <= dpc_d;
      npc_q    <= npc_d;
      first_q  <= first_d;
      ack_q    <= ack_d;
    end
  end

endmodule

// File: rtl/hart_debug_ctrl.sv
module hart_debug_ctrl #(
  parameter int XLEN    = 32,
  parameter int PC_STEP = 4,
  parameter logic [XLEN-1:0] BOOT_PC = 32'h0000_0080
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            halt_req_i,
  input  logic            resume_req_i,
  input  logic            wfi_i,
  input  logic            insn_valid_i,
  input  logic [XLEN-1:0] insn_pc_i,
  input  logic            csr_we_i,
  input  logic [11:0]     csr_addr_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  output logic [XLEN-1:0] csr_rdata_o,
  output logic            csr_hit_o,
  output logic            insn_kill_o,
  output logic            halted_o,
  output logic            resume_ack_o,
  output logic [XLEN-1:0] resume_pc_o,
  output logic            wfi_wake_o
);
  import dbg_pkg::*;

  logic            halted, step, first, ack, kill, trig_hit;
  logic [2:0]      cause;
  logic [XLEN-1:0] dpc, tctl, taddr, dstat;
  logic            wr_dstat, wr_dpc, wr_tctl, wr_taddr;

  always_comb begin
    dstat = '0;
    dstat[XLEN-1 -: 4] = DEBUG_VERSION;
    dstat[8:6]         = cause;
    dstat[2]           = step;
    dstat[1:0]         = 2'b11;
  end

  dbg_csr_port #(.XLEN(XLEN)) u_port (
    .halted   (halted),
    .we       (csr_we_i),
    .addr     (csr_addr_i),
    .dstat    (dstat),
    .dpc      (dpc),
    .tctl     (tctl),
    .taddr    (taddr),
    .rdata    (csr_rdata_o),
    .hit      (csr_hit_o),
    .wr_dstat (wr_dstat),
    .wr_dpc   (wr_dpc),
    .wr_tctl  (wr_tctl),
    .wr_taddr (wr_taddr)
  );

  dbg_trigger #(.XLEN(XLEN)) u_trig (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ctl    (wr_tctl),
    .wr_addr   (wr_taddr),
    .wdata     (csr_wdata_i),
    .cmp_valid (insn_valid_i && !halted),
    .cmp_pc    (insn_pc_i),
    .suppress  (first),
    .ctl_q     (tctl),
    .addr_q    (taddr),
    .hit       (trig_hit)
  );

  dbg_halt_fsm #(.XLEN(XLEN), .PC_STEP(PC_STEP), .BOOT_PC(BOOT_PC)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .halt_req   (halt_req_i),
    .resume_req (resume_req_i),
    .insn_valid (insn_valid_i),
    .insn_pc    (insn_pc_i),
    .trig_hit   (trig_hit),
    .wr_dstat   (wr_dstat),
    .wr_dpc     (wr_dpc),
    .wdata      (csr_wdata_i),
    .halted_q   (halted),
    .cause_q    (cause),
    .step_q     (step),
    .dpc_q      (dpc),
    .first_q    (first),
    .ack_q      (ack),
    .kill       (kill)
  );

  assign insn_kill_o  = kill;
  assign halted_o     = halted;
  assign resume_ack_o = ack;
  assign resume_pc_o  = dpc;
  assign wfi_wake_o   = wfi_i && halt_req_i && !halted;

endmodule

// File: rtl/hart_debug_ctrl_chk.sv
module hart_debug_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic halt_req_i,
  input logic resume_req_i,
  input logic insn_valid_i,
  input logic insn_kill_o,
  input logic halted_o,
  input logic resume_ack_o,
  input logic wfi_wake_o,
  input logic trig_hit
);

  p_halt_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted_o && halt_req_i && !insn_valid_i) |=> halted_o);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_o && !resume_req_i) |=> halted_o);

  p_kill_parked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_o && insn_valid_i) |-> insn_kill_o);

  p_ack_after_halt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    resume_ack_o |-> (!halted_o && $past(halted_o)));

  p_ack_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    resume_ack_o |=> !resume_ack_o);

  p_trig_halts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_hit && !halted_o) |=> halted_o);

  p_wake_needs_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wfi_wake_o |-> (halt_req_i && !halted_o));

endmodule

bind hart_debug_ctrl hart_debug_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .halt_req_i   (halt_req_i),
  .resume_req_i (resume_req_i),
  .insn_valid_i (insn_valid_i),
  .insn_kill_o  (insn_kill_o),
  .halted_o     (halted_o),
  .resume_ack_o (resume_ack_o),
  .wfi_wake_o   (wfi_wake_o),
  .trig_hit     (trig_hit)
);

// File: tb/hart_debug_ctrl_tb.sv
`timescale 1ns/1ps
module hart_debug_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        halt_req, resume_req, wfi, insn_valid, csr_we;
  logic [31:0] insn_pc, csr_wdata, csr_rdata, resume_pc;
  logic [11:0] csr_addr;
  logic        csr_hit, kill, halted, ack, wake;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  hart_debug_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .halt_req_i(halt_req), .resume_req_i(resume_req),
    .wfi_i(wfi), .insn_valid_i(insn_valid), .insn_pc_i(insn_pc),
    .csr_we_i(csr_we), .csr_addr_i(csr_addr), .csr_wdata_i(csr_wdata),
    .csr_rdata_o(csr_rdata), .csr_hit_o(csr_hit), .insn_kill_o(kill),
    .halted_o(halted), .resume_ack_o(ack), .resume_pc_o(resume_pc),
    .wfi_wake_o(wake)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 20000) begin
      bad   = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    csr_addr = a;
    #0.5;
    v = csr_rdata;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    csr_addr = a; csr_wdata = d; csr_we = 1'b1;
    tick();
    csr_we = 1'b0;
  endtask

  task automatic resume_chk(input logic [31:0] exp_pc);
    resume_req = 1'b1;
    tick();
    resume_req = 1'b0;
    chk("R4 ack", {31'b0, ack}, 32'd1);
    chk("R4 running", {31'b0, halted}, 32'd0);
    chk("R4 resume pc", resume_pc, exp_pc);
  endtask

  task automatic halt_chk(input string tag, input logic [2:0] cause, input logic [31:0] pc);
    logic [31:0] v;
    chk({tag, " halted"}, {31'b0, halted}, 32'd1);
    rd(12'h7B0, v);
    chk({tag, " cause"}, {29'b0, v[8:6]}, {29'b0, cause});
    rd(12'h7B1, v);
    chk({tag, " dpc"}, v, pc);
  endtask

  initial begin
    logic [31:0] v, pc, dpc_exp;
    rst_n = 1'b0; halt_req = 0; resume_req = 0; wfi = 0; insn_valid = 0;
    insn_pc = 0; csr_we = 0; csr_addr = 0; csr_wdata = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 halted", {31'b0, halted}, 32'd0);
    rd(12'h7B0, v); chk("R1 status", v, 32'h4000_0003);
    rd(12'h7A1, v); chk("R1 tctl", v, 32'hF000_0000);
    // R8 constants and address decode sweep
    rd(12'h7A4, v); chk("R8 tinfo", v, 32'h0100_0040);
    rd(12'h7A0, v); chk("R8 tsel", v, 32'd0);
    for (int a = 12'h790; a <= 12'h7BF; a++) begin
      logic e;
      e = (a == 12'h7A0) || (a == 12'h7A1) || (a == 12'h7A2) ||
          (a == 12'h7A4) || (a == 12'h7B0) || (a == 12'h7B1);
      csr_addr = 12'(a);
      #0.5;
      chk("R8 hit", {31'b0, csr_hit}, {31'b0, e});
    end
    rd(12'hDEA, v); chk("R8 miss", {31'b0, csr_hit}, 32'd0);

    // R11 writes while running ignored
    wr(12'h7A2, 32'h55);
    rd(12'h7A2, v); chk("R11 taddr", v, 32'd0);
    wr(12'h7B0, 32'h4);
    rd(12'h7B0, v); chk("R11 status", v, 32'h4000_0003);

    // R2 halt request kills offered instruction
    insn_valid = 1; insn_pc = 32'h100; #0.5; chk("R2 no kill", {31'b0, kill}, 32'd0); tick();
    insn_pc = 32'h104; tick();
    insn_pc = 32'h108; halt_req = 1; #0.5;
    chk("R2 kill", {31'b0, kill}, 32'd1);
    tick();
    halt_req = 0;
    halt_chk("R2", 3'd3, 32'h108);

    // R3 stays halted, instructions killed
    insn_pc = 32'h300;
    for (int i = 0; i < 40; i++) begin
      #0.5;
      chk("R3 kill", {31'b0, kill}, 32'd1);
      tick();
      chk("R3 hold", {31'b0, halted}, 32'd1);
    end
    insn_valid = 0;

    // R5 single step sweep
    wr(12'h7B0, 32'h4);
    rd(12'h7B0, v); chk("R5 step set", {31'b0, v[2]}, 32'd1);
    dpc_exp = 32'h108;
    for (int k = 0; k < 3; k++) begin
      resume_chk(dpc_exp);
      insn_valid = 1; insn_pc = dpc_exp; #0.5;
      chk("R5 commits", {31'b0, kill}, 32'd0);
      tick();
      insn_valid = 0;
      chk("R4 ack drop", {31'b0, ack}, 32'd0);
      dpc_exp = dpc_exp + 4;
      halt_chk("R5", 3'd4, dpc_exp);
    end
    wr(12'h7B0, 32'h0);

    // R7 control word encodings
    wr(12'h7A1, 32'h0);
    rd(12'h7A1, v); chk("R7 off", v, 32'hF000_0000);
    wr(12'h7A1, 32'h1234_5678);
    rd(12'h7A1, v); chk("R7 other type", v, 32'hF000_0000);
    wr(12'h7A2, 32'h200);
    rd(12'h7A2, v); chk("R6 taddr", v, 32'h200);
    wr(12'h7A1, 32'h6243_1044);
    rd(12'h7A1, v); chk("R7 armed rb", v, 32'h6243_1044);

    // R6 walk to trigger
    resume_chk(dpc_exp);
    pc = dpc_exp;
    insn_valid = 1;
    while (pc != 32'h200) begin
      insn_pc = pc; #0.5;
      chk("R6 pre-match", {31'b0, kill}, 32'd0);
      tick();
      pc = pc + 4;
    end
    insn_pc = 32'h200; #0.5;
    chk("R6 kill", {31'b0, kill}, 32'd1);
    tick();
    insn_valid = 0;
    halt_chk("R6", 3'd2, 32'h200);

    // R9 resume at breakpoint
    resume_chk(32'h200);
    insn_valid = 1; insn_pc = 32'h200; #0.5;
    chk("R9 suppressed", {31'b0, kill}, 32'd0);
    tick();
    chk("R9 running", {31'b0, halted}, 32'd0);
    insn_pc = 32'h204; tick();
    insn_pc = 32'h200; #0.5;
    chk("R9 refire", {31'b0, kill}, 32'd1);
    tick();
    insn_valid = 0;
    halt_chk("R9", 3'd2, 32'h200);

    // R7 type 6 without execute bit does not arm
    wr(12'h7A1, 32'h6243_1040);
    rd(12'h7A1, v); chk("R7 disarm rb", v, 32'h6243_1040);
    resume_chk(32'h200);
    insn_valid = 1; insn_pc = 32'h200; tick();
    insn_pc = 32'h200; #0.5;
    chk("R7 no match", {31'b0, kill}, 32'd0);
    tick();
    insn_valid = 0;
    chk("R7 running", {31'b0, halted}, 32'd0);

    // R10 wake from wait-for-interrupt
    wfi = 1; #0.5;
    chk("R10 no req", {31'b0, wake}, 32'd0);
    halt_req = 1; #0.5;
    chk("R10 wake", {31'b0, wake}, 32'd1);
    tick();
    halt_req = 0; wfi = 0;
    halt_chk("R10", 3'd3, 32'h204);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule